// File: doc/BRIEF.md
# Self-Timed Nonvolatile Array Erase/Program Controller

This block holds the 16-bit operation control register of a nonvolatile memory array and times each erase or program cycle by itself. Software first stores the operation code with the top bit clear, then writes the same code with bit 15 set to launch it. The block decodes the low fifteen bits into one of five operation classes: whole-array erase, configuration-only erase, erase of one, two or four rows, and word/row program. It raises an erase or program strobe with a region select and a row count for the array, and keeps them asserted for a duration that depends on the class.

When the interval runs out, the block drops the strobes and clears bit 15 in the same clock edge. Software learns that the operation has finished only by reading the register back and seeing that bit 15 is low. Durations are parameters counted in system-clock cycles, so a fast simulation can use short values and silicon can use the real millisecond figures. A launch with a code the block does not know never reaches the array. Bit 15 drops again on the next edge and an error flag is set.

Top module: `flash_op_ctrl`

## Requirements
- R1: After synchronous reset `ctrl_q` is 0000h, `err_q` is 0, `arr_erase` and `arr_prog` are 0, `arr_sel` is 00 and `arr_rows` is 0.
- R2: While `ctrl_q[15]` is 0, a cycle with `wr_en` high loads `wr_data` into the register, and the value reads back on `ctrl_q` from the next cycle on.
- R3: A launch of C064h asserts `arr_erase` with `arr_sel` = 11 (code and configuration) and `arr_rows` = 0 for BULK_CYC cycles.
- R4: Launches of C058h, C059h and C05Ah assert `arr_erase` with `arr_rows` = 1, 2 and 4. `arr_sel` is 00 when `tgt_cfg` is 0 at the write and 01 when it is 1. One or two rows last ROW_CYC cycles and four rows last QUAD_CYC cycles.
- R5: A launch of C004h asserts `arr_prog` for PROG_CYC cycles, with `arr_rows` = 1 and `arr_sel` taken from `tgt_cfg` as in R4.
- R6: A launch of C054h asserts `arr_erase` with `arr_sel` = 01 and `arr_rows` = 0 for CFGE_CYC cycles.
- R7: After a valid launch, `ctrl_q[15]` reads 1 for exactly the operation's cycle count. It then clears on the same edge that drops the strobes, and bits 14:0 keep the launched code.
- R8: A write while `ctrl_q[15]` is 1 is ignored: the register, the strobes and the timing stay unchanged.
- R9: A launch with any other low-15-bit code never asserts a strobe. `ctrl_q[15]` reads 1 for one cycle and then clears, and `err_q` rises and stays set until the next accepted write clears it.
- R10: An accepted write with bit 15 clear starts no operation and clears `err_q`, even when its low bits hold a valid code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Value to write; bit 15 launches |
| tgt_cfg | input | 1 | Destination lies in configuration space (1) or code space (0) |
| ctrl_q | output | 16 | Register readback for polling |
| err_q | output | 1 | Last launch used an unsupported code |
| arr_erase | output | 1 | Erase strobe to the array |
| arr_prog | output | 1 | Program strobe to the array |
| arr_sel | output | 2 | Region: 00 code, 01 configuration, 11 both |
| arr_rows | output | 3 | Rows covered by the operation (0 when not row-based) |

## Verification
A counter that reloads wrongly or stops one cycle early or late moves the falling edge of `ctrl_q[15]`. A poll at every cycle sees that as a wrong operation length at the end of the first launch. A decode fault shows up in the cycle right after the launch as the wrong strobe, region or row count, or as a missing error flag. A write guard that leaks changes the readback value one cycle after the blocked write.

// File: rtl/flash_op_pkg.sv
package flash_op_pkg;
  typedef enum logic [2:0] {
    OPC_NONE, OPC_BULK, OPC_ROWS, OPC_QUAD, OPC_PROG, OPC_CFGE
  } opc_e;

  localparam logic [1:0] SEL_CODE = 2'b00;
  localparam logic [1:0] SEL_CFG  = 2'b01;
  localparam logic [1:0] SEL_ALL  = 2'b11;

  localparam logic [14:0] CODE_BULK  = 15'h4064;
  localparam logic [14:0] CODE_ROW1  = 15'h4058;
  localparam logic [14:0] CODE_ROW2  = 15'h4059;
  localparam logic [14:0] CODE_ROW4  = 15'h405A;
  localparam logic [14:0] CODE_PROG  = 15'h4004;
  localparam logic [14:0] CODE_CFGE  = 15'h4054;
endpackage

// File: rtl/flash_op_decode.sv
module flash_op_decode
  import flash_op_pkg::*;
(
  input  logic [14:0] code,
  input  logic        tgt_cfg,
  output opc_e        opc,
  output logic        dec_erase,
  output logic        dec_prog,
  output logic [1:0]  dec_sel,
  output logic [2:0]  dec_rows
);
  logic [1:0] by_addr;
  assign by_addr = tgt_cfg ? SEL_CFG : SEL_CODE;

  always_comb begin
    opc       = OPC_NONE;
    dec_erase = 1'b0;
    dec_prog  = 1'b0;
    dec_sel   = SEL_CODE;
    dec_rows  = 3'd0;
    case (code)
      CODE_BULK: begin opc = OPC_BULK; dec_erase = 1'b1; dec_sel = SEL_ALL; end
      CODE_CFGE: begin opc = OPC_CFGE; dec_erase = 1'b1; dec_sel = SEL_CFG; end
      CODE_ROW1: begin opc = OPC_ROWS; dec_erase = 1'b1; dec_sel = by_addr; dec_rows = 3'd1; end
      CODE_ROW2: begin opc = OPC_ROWS; dec_erase = 1'b1; dec_sel = by_addr; dec_rows = 3'd2; end
      CODE_ROW4: begin opc = OPC_QUAD; dec_erase = 1'b1; dec_sel = by_addr; dec_rows = 3'd4; end
      CODE_PROG: begin opc = OPC_PROG; dec_prog  = 1'b1; dec_sel = by_addr; dec_rows = 3'd1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] ld_val,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= ld_val;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  assert_load_busy_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> !busy);
endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
  import flash_op_pkg::*;
#(
  parameter int unsigned BULK_CYC = 500000,
  parameter int unsigned QUAD_CYC = 500000,
  parameter int unsigned ROW_CYC  = 300000,
  parameter int unsigned PROG_CYC = 200000,
  parameter int unsigned CFGE_CYC = 500000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        tgt_cfg,
  output logic [15:0] ctrl_q,
  output logic        err_q,
  output logic        arr_erase,
  output logic        arr_prog,
  output logic [1:0]  arr_sel,
  output logic [2:0]  arr_rows
);
  localparam int unsigned MAX_A = (BULK_CYC > QUAD_CYC) ? BULK_CYC : QUAD_CYC;
  localparam int unsigned MAX_B = (ROW_CYC > PROG_CYC) ? ROW_CYC : PROG_CYC;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAXD  = (MAX_C > CFGE_CYC) ? MAX_C : CFGE_CYC;
  localparam int unsigned CW    = $clog2(MAXD + 1);

  opc_e          opc;
  logic          dec_erase, dec_prog;
  logic [1:0]    dec_sel;
  logic [2:0]    dec_rows;
  logic [CW-1:0] dur_m1;
  logic          accept, start_ok, start_bad, busy, done;
  logic [15:0]   ctrl_r;
  logic          err_r, rej_r, erase_r, prog_r;
  logic [1:0]    sel_r;
  logic [2:0]    rows_r;

  flash_op_decode u_dec (
    .code(wr_data[14:0]), .tgt_cfg(tgt_cfg), .opc(opc),
    .dec_erase(dec_erase), .dec_prog(dec_prog),
    .dec_sel(dec_sel), .dec_rows(dec_rows)
  );

  always_comb begin
    case (opc)
      OPC_BULK: dur_m1 = CW'(BULK_CYC - 1);
      OPC_QUAD: dur_m1 = CW'(QUAD_CYC - 1);
      OPC_ROWS: dur_m1 = CW'(ROW_CYC - 1);
      OPC_PROG: dur_m1 = CW'(PROG_CYC - 1);
      OPC_CFGE: dur_m1 = CW'(CFGE_CYC - 1);
      default:  dur_m1 = '0;
    endcase
  end

  assign accept    = wr_en && !ctrl_r[15];
  assign start_ok  = accept && wr_data[15] && (opc != OPC_NONE);
  assign start_bad = accept && wr_data[15] && (opc == OPC_NONE);

  flash_op_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(start_ok), .ld_val(dur_m1),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_r  <= '0;
      err_r   <= 1'b0;
      rej_r   <= 1'b0;
      erase_r <= 1'b0;
      prog_r  <= 1'b0;
      sel_r   <= SEL_CODE;
      rows_r  <= '0;
    end else begin
      if (accept) begin
        ctrl_r <= wr_data;
        err_r  <= start_bad;
        rej_r  <= start_bad;
      end
      if (start_ok) begin
        erase_r <= dec_erase;
        prog_r  <= dec_prog;
        sel_r   <= dec_sel;
        rows_r  <= dec_rows;
      end else if (done) begin
        ctrl_r[15] <= 1'b0;
        erase_r    <= 1'b0;
        prog_r     <= 1'b0;
        sel_r      <= SEL_CODE;
        rows_r     <= '0;
      end
      if (rej_r) begin
        ctrl_r[15] <= 1'b0;
        rej_r      <= 1'b0;
      end
    end
  end

  assign ctrl_q    = ctrl_r;
  assign err_q     = err_r;
  assign arr_erase = erase_r;
  assign arr_prog  = prog_r;
  assign arr_sel   = sel_r;
  assign arr_rows  = rows_r;

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(arr_erase && arr_prog));
  assert_strobe_start_R7: assert property (@(posedge clk) disable iff (rst)
    (arr_erase || arr_prog) |-> ctrl_q[15]);
  assert_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[15] && wr_en) |=> $stable(ctrl_q[14:0]));
  assert_reject_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (err_q && ctrl_q[15]) |=> (!ctrl_q[15] && !arr_erase && !arr_prog));
  assert_busy_match_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (ctrl_q[15] && (arr_erase || arr_prog)));
endmodule

// File: tb/flash_op_ctrl_test.sv
module flash_op_ctrl_test;
  localparam int BULK = 40, QUAD = 30, ROW = 12, PROG = 8, CFGE = 20;

  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, tgt_cfg = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_q;
  logic        err_q, arr_erase, arr_prog;
  logic [1:0]  arr_sel;
  logic [2:0]  arr_rows;

  int total = 0, bad = 0, wd = 0;
  bit model_on = 0;

  // reference model state
  logic [15:0] m_ctrl;
  bit          m_err, m_rej, m_er, m_pg;
  int          m_left, m_sel, m_rows;

  always #5 clk = ~clk;

  flash_op_ctrl #(.BULK_CYC(BULK), .QUAD_CYC(QUAD), .ROW_CYC(ROW),
                  .PROG_CYC(PROG), .CFGE_CYC(CFGE)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tgt_cfg(tgt_cfg),
    .ctrl_q(ctrl_q), .err_q(err_q), .arr_erase(arr_erase), .arr_prog(arr_prog),
    .arr_sel(arr_sel), .arr_rows(arr_rows)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_err = 0; m_rej = 0; m_er = 0; m_pg = 0;
      m_left = 0; m_sel = 0; m_rows = 0;
    end else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) begin
        m_ctrl[15] = 0; m_er = 0; m_pg = 0; m_sel = 0; m_rows = 0;
      end
    end else if (m_rej) begin
      m_ctrl[15] = 0; m_rej = 0;
    end else if (wr_en) begin
      int lo, reg_sel, d;
      m_ctrl = wr_data;
      m_err = 0;
      if (wr_data[15]) begin
        lo = int'(wr_data[14:0]);
        reg_sel = tgt_cfg ? 1 : 0;
        d = 0;
        if (lo == 'h4064)      begin d = BULK; m_er = 1; m_sel = 3; m_rows = 0; end
        else if (lo == 'h4054) begin d = CFGE; m_er = 1; m_sel = 1; m_rows = 0; end
        else if (lo == 'h4058) begin d = ROW;  m_er = 1; m_sel = reg_sel; m_rows = 1; end
        else if (lo == 'h4059) begin d = ROW;  m_er = 1; m_sel = reg_sel; m_rows = 2; end
        else if (lo == 'h405A) begin d = QUAD; m_er = 1; m_sel = reg_sel; m_rows = 4; end
        else if (lo == 'h4004) begin d = PROG; m_pg = 1; m_sel = reg_sel; m_rows = 1; end
        if (d == 0) begin m_err = 1; m_rej = 1; end
        else m_left = d;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on) begin
      chk(ctrl_q == m_ctrl, "R2/R7 ctrl_q", ctrl_q, m_ctrl);
      chk(err_q == m_err, "R9 err_q", err_q, m_err);
      chk(arr_erase == m_er, "R3 arr_erase", arr_erase, m_er);
      chk(arr_prog == m_pg, "R5 arr_prog", arr_prog, m_pg);
      chk(int'(arr_sel) == m_sel, "R4 arr_sel", arr_sel, m_sel);
      chk(int'(arr_rows) == m_rows, "R4 arr_rows", arr_rows, m_rows);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // launch, then count cycles with bit 15 high; optionally try a blocked write
  task automatic run_op(input logic [15:0] v, input bit cfg, input int exp_dur,
                        input string tag);
    int n = 0;
    @(negedge clk); wr_en = 1; wr_data = v; tgt_cfg = cfg;
    @(negedge clk); wr_en = 0; tgt_cfg = 0;
    while (ctrl_q[15] && n < 1000) begin
      n++;
      if (n == 2) begin wr_en = 1; wr_data = 16'h0000; end // R8 blocked write
      else wr_en = 0;
      @(negedge clk);
    end
    wr_en = 0;
    chk(n == exp_dur, {tag, " R7 duration"}, n, exp_dur);
    chk(ctrl_q == {1'b0, v[14:0]}, {tag, " R8 low bits kept"}, ctrl_q, {1'b0, v[14:0]});
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(ctrl_q == 0 && err_q == 0 && !arr_erase && !arr_prog && arr_sel == 0 && arr_rows == 0,
        "R1 reset", {ctrl_q, err_q}, 0);
    model_on = 1;

    wr(16'h1234);
    chk(ctrl_q == 16'h1234, "R2 readback", ctrl_q, 16'h1234);
    wr(16'h4064);
    chk(!arr_erase && !ctrl_q[15], "R10 no launch", {arr_erase, ctrl_q}, 16'h4064);

    run_op(16'hC064, 0, BULK, "R3 bulk");
    run_op(16'hC058, 0, ROW,  "R4 row1");
    run_op(16'hC059, 1, ROW,  "R4 row2");
    run_op(16'hC05A, 0, QUAD, "R4 row4");
    run_op(16'hC004, 0, PROG, "R5 prog code");
    run_op(16'hC004, 1, PROG, "R5 prog cfg");
    run_op(16'hC054, 1, CFGE, "R6 cfg erase");

    run_op(16'hC123, 0, 1, "R9 bad code");
    chk(err_q == 1, "R9 err set", err_q, 1);
    run_op(16'hC065, 0, 1, "R9 near code");
    chk(err_q == 1 && !arr_erase, "R9 err held", err_q, 1);
    wr(16'h0001);
    chk(err_q == 0, "R10 err cleared", err_q, 0);

    run_op(16'hC05A, 1, QUAD, "R4 row4 cfg");
    repeat (3) @(negedge clk);
    model_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule